// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block decides which pending interrupt the core takes next and keeps the core's current priority level. Each peripheral request line and each debug request line has a 2-bit configuration field. The field either assigns the line a priority level or switches it off. There is also a non-maskable request fixed at level 3 and a software-interrupt request fixed at the lowest level, 0. The current level masks every request whose level is below it. When a request is taken, the level rises, and the value it had before is saved on a small hardware stack, so a handler can itself be preempted by a higher-level request.

When the controller takes a request, it emits a one-cycle take pulse together with a vector index that identifies the winning source. A return strobe from the core, sent when a handler finishes, pops the stack and restores the level that applied before that handler started. Software can also write the current level directly. This is how the level is brought down from its reset value of 3.

Top module: `nipc_core`

## Requirements
- R1: After reset the current level is 3, no take pulse is issued and the overflow flag is clear. A peripheral request at levels 0 to 2 is not taken while the level is 3.
- R2: When `lvl_wr_i` is high and `ret_i` is low, the current level equals `lvl_wr_val_i` one cycle later.
- R3: Peripheral configuration codes work as follows: 0, 1 and 2 select that level, and code 3 disables the line. Debug configuration codes work as follows: 0 disables the line, and 1, 2 and 3 select that level. A disabled line is never taken.
- R4: A request is eligible only when its level is greater than or equal to the current level.
- R5: Among the eligible requests, the highest level wins, and a tie goes to the lowest vector index. The vector map is: non-maskable = 0, software = 1, debug line j = 2+j, peripheral line i = 2+NUM_DBG+i.
- R6: Taking a request of level L below 3 sets the current level to L+1 in the same cycle that the take pulse is high.
- R7: Taking a level-3 request leaves the current level at 3.
- R8: The software interrupt has a fixed level of 0. A rising edge on `swi_i` latches it as pending. Taking it clears the pending state and leaves the current level unchanged.
- R9: The non-maskable request has a fixed level of 3. A rising edge on `nmi_i` latches it as pending, and it is taken at any current level.
- R10: Each take pushes the previous level. Each return pops it, so nested handlers restore their levels in reverse order.
- R11: The stack holds STACK_DEPTH levels (4 by default). A take with the stack full drops the push and sets `ovf_o`, which stays set until reset.
- R12: A return with an empty stack leaves the current level unchanged.
- R13: The take pulse is high for exactly one cycle. No take is issued in the cycle after a take, or in a cycle in which `ret_i` or `lvl_wr_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| per_req_i | input | NUM_PER | Level-sensitive peripheral request lines |
| per_cfg_i | input | 2*NUM_PER | Peripheral configuration, 2 bits per line (0..2 level, 3 off) |
| dbg_req_i | input | NUM_DBG | Level-sensitive debug request lines |
| dbg_cfg_i | input | 2*NUM_DBG | Debug configuration, 2 bits per line (0 off, 1..3 level) |
| nmi_i | input | 1 | Non-maskable request, rising edge captured |
| swi_i | input | 1 | Software interrupt request, rising edge captured |
| ret_i | input | 1 | Handler-finished strobe |
| lvl_wr_i | input | 1 | Software write of the current level |
| lvl_wr_val_i | input | 2 | Level value to write |
| take_o | output | 1 | One-cycle interrupt-take pulse |
| vec_o | output | VEC_W | Vector index of the taken source |
| lvl_o | output | 2 | Current priority level |
| ovf_o | output | 1 | Sticky level-stack overflow flag |

## Verification
The assertions assume a well-behaved environment. They take for granted that the core sends `ret_i` only for a handler it actually entered, and that a level-sensitive request is withdrawn after its take and before the matching return. Under that assumption, a held request cannot be retaken once the level drops back.

A level-3 debug line that stays high is taken again on every other cycle. The bench holds one high deliberately to observe the spacing rule, and otherwise releases every request in the cycle in which its take is seen. All stimulus changes on the falling clock edge, so each input is stable before the rising edge that evaluates it.

// File: rtl/nipc_pkg.sv
package nipc_pkg;

  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_TOP = 2'd3;

  localparam int VEC_NMI = 0;
  localparam int VEC_SWI = 1;
  localparam int VEC_DBG0 = 2;

  function automatic lvl_t next_level(input lvl_t l);
    return (l == LVL_TOP) ? LVL_TOP : lvl_t'(l + 2'd1);
  endfunction

endpackage

// File: rtl/nipc_src_map.sv
module nipc_src_map
  import nipc_pkg::*;
#(
  parameter int NUM_PER = 8,
  parameter int NUM_DBG = 2,
  parameter int NUM_ALL = NUM_PER + NUM_DBG + 2
) (
  input  logic [NUM_PER-1:0]   per_req_i,
  input  logic [2*NUM_PER-1:0] per_cfg_i,
  input  logic [NUM_DBG-1:0]   dbg_req_i,
  input  logic [2*NUM_DBG-1:0] dbg_cfg_i,
  input  logic                 nmi_pend_i,
  input  logic                 swi_pend_i,
  output logic [NUM_ALL-1:0]   cand_vld_o,
  output lvl_t [NUM_ALL-1:0]   cand_lvl_o
);

  localparam int PER_BASE = VEC_DBG0 + NUM_DBG;

  assign cand_vld_o[VEC_NMI] = nmi_pend_i;
  assign cand_lvl_o[VEC_NMI] = LVL_TOP;
  assign cand_vld_o[VEC_SWI] = swi_pend_i;
  assign cand_lvl_o[VEC_SWI] = 2'd0;

  // Debug lines: code 0 switches the line off, codes 1..3 give the level.
  for (genvar j = 0; j < NUM_DBG; j++) begin : g_dbg
    assign cand_vld_o[VEC_DBG0+j] = dbg_req_i[j] && (dbg_cfg_i[2*j +: 2] != 2'd0);
    assign cand_lvl_o[VEC_DBG0+j] = dbg_cfg_i[2*j +: 2];
  end

  // Peripheral lines: code 3 switches the line off, codes 0..2 give the level.
  for (genvar i = 0; i < NUM_PER; i++) begin : g_per
    assign cand_vld_o[PER_BASE+i] = per_req_i[i] && (per_cfg_i[2*i +: 2] != 2'd3);
    assign cand_lvl_o[PER_BASE+i] = per_cfg_i[2*i +: 2];
  end

endmodule

// File: rtl/nipc_pick.sv
module nipc_pick
  import nipc_pkg::*;
#(
  parameter int NUM_ALL = 12,
  parameter int VEC_W   = $clog2(NUM_ALL)
) (
  input  logic [NUM_ALL-1:0] vld_i,
  input  lvl_t [NUM_ALL-1:0] lvl_i,
  input  lvl_t               cur_lvl_i,
  output logic               hit_o,
  output logic [VEC_W-1:0]   win_idx_o,
  output lvl_t               win_lvl_o
);

  // Scan from the top index down. A lower index replaces the current winner
  // on an equal level, so the lowest index wins a tie.
  always_comb begin
    hit_o     = 1'b0;
    win_idx_o = '0;
    win_lvl_o = '0;
    for (int i = NUM_ALL - 1; i >= 0; i--) begin
      if (vld_i[i] && (lvl_i[i] >= cur_lvl_i)) begin
        if (!hit_o || (lvl_i[i] >= win_lvl_o)) begin
          hit_o     = 1'b1;
          win_idx_o = VEC_W'(i);
          win_lvl_o = lvl_i[i];
        end
      end
    end
  end

endmodule

// File: rtl/nipc_lvl_stack.sv
module nipc_lvl_stack
  import nipc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic push_i,
  input  lvl_t push_val_i,
  input  logic pop_i,
  output lvl_t top_o,
  output logic empty_o,
  output logic ovf_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  lvl_t          mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] top_idx;
  logic          full;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign top_idx = cnt_q - CW'(1);
  assign top_o   = mem[top_idx[PW-1:0]];

  // Storage carries no reset so that it maps to plain memory.
  always_ff @(posedge clk) begin
    if (push_i && !pop_i && !full) mem[cnt_q[PW-1:0]] <= push_val_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else if (pop_i) begin
      if (!empty_o) cnt_q <= cnt_q - CW'(1);
    end else if (push_i) begin
      if (full) ovf_o <= 1'b1;
      else      cnt_q <= cnt_q + CW'(1);
    end
  end

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);
  assert_depth_bound_R11: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  assert_full_push_flags_R11: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && full) |=> ovf_o && $stable(cnt_q));

endmodule

// File: rtl/nipc_core.sv
module nipc_core
  import nipc_pkg::*;
#(
  parameter int NUM_PER     = 8,
  parameter int NUM_DBG     = 2,
  parameter int STACK_DEPTH = 4,
  parameter int VEC_W       = $clog2(NUM_PER + NUM_DBG + 2)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PER-1:0]   per_req_i,
  input  logic [2*NUM_PER-1:0] per_cfg_i,
  input  logic [NUM_DBG-1:0]   dbg_req_i,
  input  logic [2*NUM_DBG-1:0] dbg_cfg_i,
  input  logic                 nmi_i,
  input  logic                 swi_i,
  input  logic                 ret_i,
  input  logic                 lvl_wr_i,
  input  logic [1:0]           lvl_wr_val_i,
  output logic                 take_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic [1:0]           lvl_o,
  output logic                 ovf_o
);

  localparam int NUM_ALL = NUM_PER + NUM_DBG + 2;

  logic               nmi_d_q, swi_d_q, nmi_pend_q, swi_pend_q;
  logic [NUM_ALL-1:0] cand_vld;
  lvl_t [NUM_ALL-1:0] cand_lvl;
  logic               hit;
  logic [VEC_W-1:0]   win_idx;
  lvl_t               win_lvl;
  logic               take_go, take_nmi, take_swi;
  lvl_t               lvl_q, stk_top;
  logic               stk_empty;

  nipc_src_map #(.NUM_PER(NUM_PER), .NUM_DBG(NUM_DBG), .NUM_ALL(NUM_ALL)) u_map (
    .per_req_i (per_req_i),
    .per_cfg_i (per_cfg_i),
    .dbg_req_i (dbg_req_i),
    .dbg_cfg_i (dbg_cfg_i),
    .nmi_pend_i(nmi_pend_q),
    .swi_pend_i(swi_pend_q),
    .cand_vld_o(cand_vld),
    .cand_lvl_o(cand_lvl)
  );

  nipc_pick #(.NUM_ALL(NUM_ALL), .VEC_W(VEC_W)) u_pick (
    .vld_i    (cand_vld),
    .lvl_i    (cand_lvl),
    .cur_lvl_i(lvl_q),
    .hit_o    (hit),
    .win_idx_o(win_idx),
    .win_lvl_o(win_lvl)
  );

  // No take right after a take, or while a return or level write is in flight.
  assign take_go  = hit && !take_o && !ret_i && !lvl_wr_i;
  assign take_nmi = take_go && (win_idx == VEC_W'(VEC_NMI));
  assign take_swi = take_go && (win_idx == VEC_W'(VEC_SWI));

  nipc_lvl_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push_i    (take_go),
    .push_val_i(lvl_q),
    .pop_i     (ret_i),
    .top_o     (stk_top),
    .empty_o   (stk_empty),
    .ovf_o     (ovf_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_d_q    <= 1'b0;
      swi_d_q    <= 1'b0;
      nmi_pend_q <= 1'b0;
      swi_pend_q <= 1'b0;
    end else begin
      nmi_d_q    <= nmi_i;
      swi_d_q    <= swi_i;
      nmi_pend_q <= (nmi_i && !nmi_d_q) || (nmi_pend_q && !take_nmi);
      swi_pend_q <= (swi_i && !swi_d_q) || (swi_pend_q && !take_swi);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= LVL_TOP;
      take_o <= 1'b0;
      vec_o  <= '0;
    end else begin
      take_o <= take_go;
      if (take_go) vec_o <= win_idx;
      if (ret_i) begin
        if (!stk_empty) lvl_q <= stk_top;
      end else if (lvl_wr_i) begin
        lvl_q <= lvl_wr_val_i;
      end else if (take_go && !take_swi) begin
        lvl_q <= next_level(win_lvl);
      end
    end
  end

  assign lvl_o = lvl_q;

  assert_take_pulse_R13: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !take_o);
  assert_blocked_take_R13: assert property (@(posedge clk) disable iff (rst)
    (ret_i || lvl_wr_i) |=> !take_o);
  assert_level_write_R2: assert property (@(posedge clk) disable iff (rst)
    (lvl_wr_i && !ret_i) |=> (lvl_o == $past(lvl_wr_val_i)));
  assert_take_raises_R6: assert property (@(posedge clk) disable iff (rst)
    (take_o && vec_o != VEC_W'(VEC_SWI)) |-> ((lvl_o == 2'd3) || (lvl_o > $past(lvl_o))));
  assert_nmi_top_R9: assert property (@(posedge clk) disable iff (rst)
    (take_o && vec_o == VEC_W'(VEC_NMI)) |-> (lvl_o == 2'd3));
  assert_swi_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (take_o && vec_o == VEC_W'(VEC_SWI)) |-> $stable(lvl_o));
  assert_empty_pop_R12: assert property (@(posedge clk) disable iff (rst)
    (ret_i && stk_empty) |=> $stable(lvl_o));

endmodule

// File: tb/sim_nipc_core.sv
module sim_nipc_core;

  localparam int NP = 8;
  localparam int ND = 2;
  localparam int VW = $clog2(NP + ND + 2);
  localparam int PB = 2 + ND;

  logic          clk = 1'b0;
  logic          rst;
  logic [NP-1:0]   per_req;
  logic [2*NP-1:0] per_cfg;
  logic [ND-1:0]   dbg_req;
  logic [2*ND-1:0] dbg_cfg;
  logic          nmi, swi, ret, lvl_wr;
  logic [1:0]    lvl_wr_val;
  logic          take;
  logic [VW-1:0] vec;
  logic [1:0]    lvl;
  logic          ovf;

  int n_run = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  nipc_core #(.NUM_PER(NP), .NUM_DBG(ND), .STACK_DEPTH(4)) u0 (
    .clk(clk), .rst(rst), .per_req_i(per_req), .per_cfg_i(per_cfg),
    .dbg_req_i(dbg_req), .dbg_cfg_i(dbg_cfg), .nmi_i(nmi), .swi_i(swi),
    .ret_i(ret), .lvl_wr_i(lvl_wr), .lvl_wr_val_i(lvl_wr_val),
    .take_o(take), .vec_o(vec), .lvl_o(lvl), .ovf_o(ovf)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; per_req = '0; per_cfg = '1; dbg_req = '0; dbg_cfg = '0;
    nmi = 0; swi = 0; ret = 0; lvl_wr = 0; lvl_wr_val = 0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic write_lvl(input logic [1:0] v);
    lvl_wr = 1'b1; lvl_wr_val = v;
    step();
    lvl_wr = 1'b0;
  endtask

  task automatic do_ret();
    ret = 1'b1;
    step();
    ret = 1'b0;
  endtask

  task automatic nmi_pulse();
    nmi = 1'b1;
    step();
    nmi = 1'b0;
    step();
  endtask

  task automatic t_reset();
    do_reset();
    step();
    check("R1 level after reset", lvl, 3);
    check("R1 take after reset", take, 0);
    check("R1 ovf after reset", ovf, 0);
    per_cfg[1:0] = 2'd2; per_req[0] = 1'b1;
    step();
    check("R1 masked at level 3", take, 0);
    per_req[0] = 1'b0;
    write_lvl(2'd2);
    check("R2 level written", lvl, 2);
    do_ret();
    check("R12 empty pop keeps level", lvl, 2);
  endtask

  task automatic t_nested();
    do_reset();
    write_lvl(2'd0);
    check("R2 level written to 0", lvl, 0);
    per_cfg[1:0] = 2'd1; per_req[0] = 1'b1;
    step();
    check("R6 take level1", take, 1);
    check("R5 vector p0", vec, PB + 0);
    check("R6 level 1 -> 2", lvl, 2);
    per_req[0] = 1'b0;
    per_cfg[3:2] = 2'd1; per_req[1] = 1'b1;
    step();
    check("R4 level1 masked at 2", take, 0);
    per_req[1] = 1'b0;
    per_cfg[5:4] = 2'd2; per_req[2] = 1'b1;
    step();
    check("R4 level2 preempts", take, 1);
    check("R5 vector p2", vec, PB + 2);
    check("R6 level 2 -> 3", lvl, 3);
    per_req[2] = 1'b0;
    do_ret();
    check("R10 first return", lvl, 2);
    do_ret();
    check("R10 second return", lvl, 0);
  endtask

  task automatic t_config();
    do_reset();
    write_lvl(2'd0);
    per_cfg[7:6] = 2'd3; per_req[3] = 1'b1;
    dbg_cfg[1:0] = 2'd0; dbg_req[0] = 1'b1;
    step(); step();
    check("R3 disabled lines ignored", take, 0);
    check("R3 level unchanged", lvl, 0);
    per_req = '0; dbg_req = '0;
    write_lvl(2'd3);
    dbg_cfg[3:2] = 2'd3; dbg_req[1] = 1'b1;
    step();
    check("R3 debug level3 taken", take, 1);
    check("R5 vector dbg1", vec, 3);
    check("R7 level stays 3", lvl, 3);
    dbg_req = '0;
  endtask

  task automatic t_priority();
    do_reset();
    write_lvl(2'd0);
    per_cfg[1:0] = 2'd1; per_cfg[7:6] = 2'd2; per_cfg[11:10] = 2'd2;
    per_req[0] = 1'b1; per_req[3] = 1'b1; per_req[5] = 1'b1;
    step();
    check("R5 highest level lowest index", vec, PB + 3);
    per_req = '0;
    do_reset();
    write_lvl(2'd0);
    per_cfg[7:6] = 2'd2; per_req[3] = 1'b1;
    dbg_cfg[1:0] = 2'd2; dbg_req[0] = 1'b1;
    step();
    check("R5 debug wins tie", vec, 2);
    per_req = '0; dbg_req = '0;
  endtask

  task automatic t_swi();
    do_reset();
    write_lvl(2'd1);
    swi = 1'b1; step(); swi = 1'b0; step();
    check("R8 swi masked at level1", take, 0);
    write_lvl(2'd0);
    check("R13 no take during write", take, 0);
    step();
    check("R8 pending swi taken", take, 1);
    check("R8 swi vector", vec, 1);
    check("R8 swi keeps level", lvl, 0);
    step(); step();
    check("R8 pending cleared", take, 0);
  endtask

  task automatic t_nmi_stack();
    do_reset();
    nmi_pulse();
    check("R9 nmi at level3", take, 1);
    check("R9 nmi vector", vec, 0);
    do_ret();
    check("R10 return after nmi", lvl, 3);
    write_lvl(2'd0);
    per_cfg[1:0] = 2'd0; per_req[0] = 1'b1;
    step();
    check("R6 level0 -> 1", lvl, 1);
    per_req[0] = 1'b0;
    nmi_pulse(); nmi_pulse(); nmi_pulse();
    check("R11 no overflow at 4", ovf, 0);
    nmi_pulse();
    check("R11 overflow set", ovf, 1);
    check("R9 level 3 after nmi", lvl, 3);
    do_ret(); check("R10 pop 1", lvl, 3);
    do_ret(); check("R10 pop 2", lvl, 3);
    do_ret(); check("R10 pop 3", lvl, 1);
    do_ret(); check("R10 pop 4", lvl, 0);
    do_ret(); check("R12 pop empty", lvl, 0);
    check("R11 overflow sticky", ovf, 1);
  endtask

  task automatic t_spacing();
    do_reset();
    dbg_cfg[1:0] = 2'd3; dbg_req[0] = 1'b1;
    step();
    check("R13 held take 1", take, 1);
    step();
    check("R13 gap after take", take, 0);
    ret = 1'b1;
    step();
    ret = 1'b0;
    check("R13 no take with return", take, 0);
    step();
    check("R13 take after return", take, 1);
    dbg_req = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R13: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_nested();
    t_config();
    t_priority();
    t_swi();
    t_nmi_stack();
    t_spacing();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule